// File: doc/BRIEF.md
# Sticky Interrupt Flag Controller

This unit collects the status of a serial audio port and turns it into a single interrupt line. Single-cycle event pulses from the port (underrun, overrun, frame error and others) are latched into sticky flags. These flags stay set until software writes ones to a dedicated clear register. Other status bits are not stored. They follow the live FIFO occupancy or a live input level, so writing to the clear register cannot remove them.

Software configures the receive/transmit FIFO threshold and an interrupt enable mask through a small register port. It reads back a 16-bit status word. The interrupt output is high for as long as any enabled status bit is set. The audio data path is outside this block.

Top module: `irqFlagUnit`

## Requirements
- R1: After reset the enable register, the threshold field and every sticky flag are zero, and the interrupt output is low. With both FIFO levels at zero, the status word reads 0x0002.
- R2: An event pulse on evtPulse bit i sets status bit i+3 at the next clock edge. The bit stays set after the pulse ends. No sticky flag becomes set without its event.
- R3: A write to the clear register (address 2) clears each sticky status bit, among bits 3 to 11, whose data bit is one. Sticky bits written with zero keep their value.
- R4: Clear-register data bits 0–2 and 12–15 have no effect. Writes to the status register (address 0) change nothing.
- R5: When an event pulse and a clear of the same bit arrive in the same cycle, the flag ends up set.
- R6: Status bit 0 is high while the receive FIFO level is at least the threshold. The threshold equals the config field at bits 8:5 of address 3, plus one, and so ranges from 1 to 16.
- R7: Status bit 1 is high while the free transmit space (16 minus the transmit level) is at least the threshold. Status bit 2 is high when bits 0 and 1 are both high.
- R8: Status bit 12 follows txCompleteLvl, bits 14:13 follow rxPackLvl, and bit 15 follows rxWordPending, all with no storage.
- R9: The enable register (address 1) stores data bits 10:0. Its bits 31:11 read as zero.
- R10: irqOut is high exactly while some status bit in 0..10 is set together with the same enable bit. Status bits 11 and up can never raise it.
- R11: The clear register always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select: 0 status, 1 enable, 2 clear, 3 config |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| evtPulse | input | 9 | Event pulses; bit i maps to status bit i+3 |
| txCompleteLvl | input | 1 | Transmission-complete level |
| rxPackLvl | input | 2 | Receive packing level |
| rxWordPending | input | 1 | Receive word not empty |
| rxFifoLevel | input | 5 | Receive FIFO occupancy, 0..16 |
| txFifoLevel | input | 5 | Transmit FIFO occupancy, 0..16 |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench targets three kinds of mistake.

- Collision: a clear and an event arrive together. A design that gives priority to the clear would lose an event. An exact clear/event collision therefore checks that the flag survives.
- Clear-mask boundaries: bits 11 and 12 sit on either side of the clearable range. A mask that is off by one would either leave the suspended flag stuck or wipe the live transmission-complete level.
- Threshold edges: the threshold is stored minus one, and the tests include level == threshold and level == threshold − 1, for both the receive count and the transmit free space. A comparator with the wrong offset or the wrong inequality flips one of these results.

The interrupt tests check that the suspended flag cannot assert the interrupt even with every enable bit written.

// File: rtl/irqFlagPkg.sv
package irqFlagPkg;
  localparam int REG_W     = 32;
  localparam int STAT_W    = 16;
  localparam int ENABLE_W  = 11;
  localparam int STICKY_LO = 3;
  localparam int STICKY_HI = 11;
  localparam int STICKY_N  = STICKY_HI - STICKY_LO + 1;
  localparam int THR_LSB   = 5;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_CLEAR  = 2'd2,
    ADDR_CONFIG = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic     wrEnable;
    logic     wrClear;
    logic     wrConfig;
    regAddr_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqStatusCtrl.sv
module irqStatusCtrl
  import irqFlagPkg::*;
(
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  output ctrlStrobe_t strobe
);
  regAddr_e addrSel;

  always_comb begin
    addrSel        = regAddr_e'(regAddr);
    strobe.wrEnable = regWrEn && (addrSel == ADDR_ENABLE);
    strobe.wrClear  = regWrEn && (addrSel == ADDR_CLEAR);
    strobe.wrConfig = regWrEn && (addrSel == ADDR_CONFIG);
    strobe.rdSel    = addrSel;
  end
endmodule

// File: rtl/fifoLevelCmp.sv
module fifoLevelCmp #(
  parameter int FIFO_DEPTH  = 16,
  parameter int LEVEL_W     = $clog2(FIFO_DEPTH + 1),
  parameter int THR_W       = $clog2(FIFO_DEPTH),
  parameter bit COUNT_SPACE = 1'b0
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic [THR_W-1:0]   thrField,
  output logic               meets
);
  localparam logic [LEVEL_W-1:0] DEPTH_V = LEVEL_W'(FIFO_DEPTH);

  logic [LEVEL_W-1:0] threshold;
  logic [LEVEL_W-1:0] amount;

  assign threshold = LEVEL_W'(thrField) + LEVEL_W'(1);

  generate
    if (COUNT_SPACE) begin : g_space
      always_comb begin
        if (level >= DEPTH_V) amount = '0;
        else                  amount = DEPTH_V - level;
      end
    end else begin : g_fill
      always_comb amount = level;
    end
  endgenerate

  assign meets = (amount >= threshold);
endmodule

// File: rtl/irqStatusDatapath.sv
module irqStatusDatapath
  import irqFlagPkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1),
  parameter int THR_W      = $clog2(FIFO_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [REG_W-1:0]    wrData,
  input  logic [STICKY_N-1:0] evtPulse,
  input  logic                txCompleteLvl,
  input  logic [1:0]          rxPackLvl,
  input  logic                rxWordPending,
  input  logic [LEVEL_W-1:0]  rxFifoLevel,
  input  logic [LEVEL_W-1:0]  txFifoLevel,
  output logic [STAT_W-1:0]   statusVec,
  output logic [ENABLE_W-1:0] enableVec,
  output logic [REG_W-1:0]    rdData
);
  logic [ENABLE_W-1:0] enableQ;
  logic [THR_W-1:0]    thrFieldQ;
  logic [STICKY_N-1:0] stickyQ;
  logic                rxReady;
  logic                txReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enableQ <= '0;
    else if (strobe.wrEnable) enableQ <= wrData[ENABLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                thrFieldQ <= '0;
    else if (strobe.wrConfig) thrFieldQ <= wrData[THR_LSB +: THR_W];
  end

  generate
    for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                      stickyQ[i] <= 1'b0;
        else if (evtPulse[i])                           stickyQ[i] <= 1'b1;
        else if (strobe.wrClear && wrData[STICKY_LO+i]) stickyQ[i] <= 1'b0;
      end
    end
  endgenerate

  fifoLevelCmp #(
    .FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W), .THR_W(THR_W), .COUNT_SPACE(1'b0)
  ) u_rxCmp (
    .level(rxFifoLevel), .thrField(thrFieldQ), .meets(rxReady)
  );

  fifoLevelCmp #(
    .FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W), .THR_W(THR_W), .COUNT_SPACE(1'b1)
  ) u_txCmp (
    .level(txFifoLevel), .thrField(thrFieldQ), .meets(txReady)
  );

  assign statusVec = {rxWordPending, rxPackLvl, txCompleteLvl, stickyQ,
                      rxReady & txReady, txReady, rxReady};
  assign enableVec = enableQ;

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      ADDR_STATUS: rdData[STAT_W-1:0]     = statusVec;
      ADDR_ENABLE: rdData[ENABLE_W-1:0]   = enableQ;
      ADDR_CLEAR:  rdData                 = '0;
      ADDR_CONFIG: rdData[THR_LSB +: THR_W] = thrFieldQ;
      default:     rdData                 = '0;
    endcase
  end
endmodule

// File: rtl/irqFlagUnit.sv
module irqFlagUnit
  import irqFlagPkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LEVEL_W   = $clog2(FIFO_DEPTH + 1),
  localparam int THR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regAddr,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [STICKY_N-1:0] evtPulse,
  input  logic                txCompleteLvl,
  input  logic [1:0]          rxPackLvl,
  input  logic                rxWordPending,
  input  logic [LEVEL_W-1:0]  rxFifoLevel,
  input  logic [LEVEL_W-1:0]  txFifoLevel,
  output logic                irqOut
);
  ctrlStrobe_t         strobe;
  logic [STAT_W-1:0]   statusVec;
  logic [ENABLE_W-1:0] enableVec;

  irqStatusCtrl u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .strobe(strobe)
  );

  irqStatusDatapath #(
    .FIFO_DEPTH(FIFO_DEPTH), .LEVEL_W(LEVEL_W), .THR_W(THR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .evtPulse(evtPulse), .txCompleteLvl(txCompleteLvl), .rxPackLvl(rxPackLvl),
    .rxWordPending(rxWordPending), .rxFifoLevel(rxFifoLevel),
    .txFifoLevel(txFifoLevel), .statusVec(statusVec), .enableVec(enableVec),
    .rdData(regRdData)
  );

  assign irqOut = |(statusVec[ENABLE_W-1:0] & enableVec);
endmodule

// File: rtl/irqFlagUnit_chk.sv
module irqFlagUnit_chk
  import irqFlagPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          regAddr,
  input logic [REG_W-1:0]    regRdData,
  input logic [STICKY_N-1:0] evtPulse,
  input logic [STAT_W-1:0]   statusVec,
  input logic [ENABLE_W-1:0] enableVec,
  input logic                irqOut
);
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((statusVec[STICKY_HI:STICKY_LO] & $past(evtPulse)) == $past(evtPulse))); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec[STICKY_HI:STICKY_LO] & ~$past(statusVec[STICKY_HI:STICKY_LO]) & ~$past(evtPulse)) == '0)); // R2

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (enableVec == '0) |-> !irqOut); // R10

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdData == '0)); // R11

  AST_ENABLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd1) |-> (regRdData[REG_W-1:ENABLE_W] == '0)); // R9
endmodule

bind irqFlagUnit irqFlagUnit_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .evtPulse(evtPulse), .statusVec(statusVec), .enableVec(enableVec),
  .irqOut(irqOut)
);

// File: tb/irqFlagUnit_bench.sv
module irqFlagUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [8:0]  evtPulse = '0;
  logic        txCompleteLvl = 1'b0;
  logic [1:0]  rxPackLvl = '0;
  logic        rxWordPending = 1'b0;
  logic [4:0]  rxFifoLevel = '0;
  logic [4:0]  txFifoLevel = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  irqFlagUnit u_irqFlagUnit (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .txCompleteLvl(txCompleteLvl), .rxPackLvl(rxPackLvl),
    .rxWordPending(rxWordPending), .rxFifoLevel(rxFifoLevel),
    .txFifoLevel(txFifoLevel), .irqOut(irqOut)
  );

  // {rxLevel, txLevel, thresholdField, expected status[2:0]}
  localparam logic [16:0] VEC [8] = '{
    {5'd0,  5'd0,  4'd0,  3'b010},
    {5'd1,  5'd0,  4'd0,  3'b111},
    {5'd3,  5'd14, 4'd3,  3'b000},
    {5'd4,  5'd12, 4'd3,  3'b111},
    {5'd16, 5'd16, 4'd15, 3'b001},
    {5'd15, 5'd0,  4'd15, 3'b010},
    {5'd8,  5'd9,  4'd7,  3'b001},
    {5'd7,  5'd8,  4'd7,  3'b010}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(input logic [8:0] v);
    @(negedge clk);
    evtPulse = v;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic pulseAndClear(input logic [8:0] v, input logic [31:0] d);
    @(negedge clk);
    evtPulse = v; regAddr = 2'd2; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    evtPulse = '0; regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, rd); check("R1 status", rd, 32'h0000_0002);
    readReg(2'd1, rd); check("R1 enable", rd, 32'h0);
    readReg(2'd3, rd); check("R1 config", rd, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R6 / R7 threshold vectors
    foreach (VEC[i]) begin
      writeReg(2'd3, {23'b0, VEC[i][6:3], 5'b0});
      rxFifoLevel = VEC[i][16:12];
      txFifoLevel = VEC[i][11:7];
      readReg(2'd0, rd);
      check("R6 rx packet flag", {31'b0, rd[0]}, {31'b0, VEC[i][0]});
      check("R7 tx space flag",  {31'b0, rd[1]}, {31'b0, VEC[i][1]});
      check("R7 duplex flag",    {31'b0, rd[2]}, {31'b0, VEC[i][2]});
    end
    readReg(2'd3, rd); check("R6 config readback", rd, 32'h0000_00E0);

    // quiet levels for directed tests
    writeReg(2'd3, 32'h0);
    rxFifoLevel = 5'd0; txFifoLevel = 5'd16;

    // R2 sticky set
    pulse(9'b0_0000_0001);
    readReg(2'd0, rd); check("R2 set", rd, 32'h0000_0008);
    repeat (3) @(negedge clk);
    readReg(2'd0, rd); check("R2 hold", rd, 32'h0000_0008);

    // R3 selective clear
    writeReg(2'd2, 32'h0000_0008);
    pulse(9'b0_0000_1100);
    readReg(2'd0, rd); check("R3 two set", rd, 32'h0000_0060);
    writeReg(2'd2, 32'h0000_0020);
    readReg(2'd0, rd); check("R3 one cleared", rd, 32'h0000_0040);
    writeReg(2'd2, 32'h0000_0048);
    readReg(2'd0, rd); check("R3 all cleared", rd, 32'h0);

    // R4 clear outside 3..11 and status writes ignored
    rxFifoLevel = 5'd16; txFifoLevel = 5'd0; txCompleteLvl = 1'b1;
    pulse(9'b1_0000_0000);
    readReg(2'd0, rd); check("R4 setup", rd, 32'h0000_1807);
    writeReg(2'd2, 32'hFFFF_F007);
    readReg(2'd0, rd); check("R4 outside clear", rd, 32'h0000_1807);
    writeReg(2'd0, 32'hFFFF_FFFF);
    readReg(2'd0, rd); check("R4 status write", rd, 32'h0000_1807);
    writeReg(2'd2, 32'h0000_0800);
    readReg(2'd0, rd); check("R3 bit11 clear", rd, 32'h0000_1007);
    rxFifoLevel = 5'd0; txFifoLevel = 5'd16; txCompleteLvl = 1'b0;

    // R5 event beats clear
    pulse(9'b0_0001_0000);
    pulseAndClear(9'b0_0001_0000, 32'h0000_0080);
    readReg(2'd0, rd); check("R5 collision", rd, 32'h0000_0080);
    pulseAndClear(9'b0_0000_0010, 32'h0000_0010);
    readReg(2'd0, rd); check("R5 fresh collision", rd, 32'h0000_0090);
    writeReg(2'd2, 32'h0000_0FF8);
    readReg(2'd0, rd); check("R3 wipe", rd, 32'h0);

    // R8 pass-through levels
    txCompleteLvl = 1'b1; rxPackLvl = 2'd2; rxWordPending = 1'b1;
    readReg(2'd0, rd); check("R8 levels", rd, 32'h0000_D000);
    writeReg(2'd2, 32'h0000_F000);
    readReg(2'd0, rd); check("R4 levels kept", rd, 32'h0000_D000);
    txCompleteLvl = 1'b0; rxPackLvl = 2'd1; rxWordPending = 1'b0;
    readReg(2'd0, rd); check("R8 levels follow", rd, 32'h0000_2000);
    rxPackLvl = 2'd0;

    // R9 enable width
    writeReg(2'd1, 32'hFFFF_FFFF);
    readReg(2'd1, rd); check("R9 enable", rd, 32'h0000_07FF);
    check("R10 idle irq", {31'b0, irqOut}, 32'h0);

    // R10 interrupt
    writeReg(2'd1, 32'h0000_0040);
    pulse(9'b0_0000_1000);
    #1 check("R10 overrun irq", {31'b0, irqOut}, 32'h1);
    writeReg(2'd2, 32'h0000_0040);
    #1 check("R10 cleared irq", {31'b0, irqOut}, 32'h0);
    writeReg(2'd1, 32'hFFFF_FFFF);
    pulse(9'b1_0000_0000);
    #1 check("R10 suspend no irq", {31'b0, irqOut}, 32'h0);
    writeReg(2'd2, 32'h0000_0800);
    writeReg(2'd1, 32'h0000_0002);
    @(negedge clk); txFifoLevel = 5'd0;
    #1 check("R10 level irq", {31'b0, irqOut}, 32'h1);
    @(negedge clk); txFifoLevel = 5'd16;
    #1 check("R10 level irq off", {31'b0, irqOut}, 32'h0);

    // R11 clear register reads zero
    writeReg(2'd2, 32'hFFFF_FFFF);
    readReg(2'd2, rd); check("R11 clear read", rd, 32'h0);

    finishRun();
  end
endmodule